// File: doc/BRIEF.md
# Periodic Interval Timer with Two Compare Channels

The block is a 16-bit up-counter that repeats a programmable interval. Compare channel 0 sets the length of the interval. The counter runs from zero up to the channel 0 value, returns to zero on the next count step, and raises a one-cycle period interrupt. Compare channel 1 does not change the interval. It raises its own one-cycle interrupt whenever the count reaches its value, and a mask input can suppress that interrupt. Both compare values are buffered, so a new value takes effect only at a period boundary.

Count steps come from one of two sources. The first is an internal count-clock enable. The second is an external event input, which is synchronised and counted on its rising edges. Each channel drives a timer output pin. When a pin is enabled, it toggles on every period match. When it is disabled, it rests at a programmable level. The live count is always visible on a read-only output.

Configuration goes through a plain, single-cycle register write port with no handshake. A write is taken on any clock edge where the strobe is high. All other pins are plain level or pulse signals.

Top module: `ivt_dual_cmp_top`

## Requirements
- R1: With compare value D0 in the period buffer and a count step on every clock, the counter visits 0, 1, … D0 and then 0 again. The period interrupt is a one-clock pulse. It first shows in the cycle where the count has just returned to 0, and it repeats every D0+1 count steps.
- R2: `count_o` always shows the current counter value. It reads 0 after reset and while the timer is stopped.
- R3: A write to compare register 1 (address 2) is copied to its buffer only at timer start and at each period boundary. The channel 1 interrupt pulse appears one clock after a count step taken while the count equals that buffer, so `count_o` then reads buffer+1. A buffer value above D0 gives no pulse.
- R4: A write to compare register 0 (address 1) in the middle of a period leaves that period's length unchanged. The new length applies from the next period.
- R5: While `cc1_mask_i` is high, no channel 1 interrupt is issued.
- R6: While a pin's enable bit is 1, the pin inverts on every period match.
- R7: While a pin's enable bit is 0, the pin drives its level bit (0 = low, 1 = high).
- R8: Clearing the run bit returns the counter to 0 and stops all period interrupts.
- R9: With the source-select bit set, only rising edges of `evt_i` advance the counter, one step per edge, and `cnt_tick_i` is ignored. With the bit clear, `evt_i` is ignored.
- R10: With the internal source selected, the counter holds its value in every clock where `cnt_tick_i` is low.
- R11: The control register is at address 0. Its bits are: bit0 run, bit1 external source select, bit2 pin 0 enable, bit3 pin 0 level, bit4 pin 1 enable, bit5 pin 1 level. A rising run bit starts the count from 0 and loads both buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 control, 1 compare 0, 2 compare 1) |
| wr_data_i | input | 16 | Write data |
| cnt_tick_i | input | 1 | Internal count-clock enable |
| evt_i | input | 1 | Asynchronous external event input |
| cc1_mask_i | input | 1 | Suppresses the channel 1 interrupt |
| count_o | output | 16 | Live counter value |
| irq_cc0_o | output | 1 | Period (compare 0) interrupt pulse |
| irq_cc1_o | output | 1 | Compare 1 interrupt pulse |
| tout0_o | output | 1 | Timer output pin, channel 0 |
| tout1_o | output | 1 | Timer output pin, channel 1 |

## Verification
The period is exercised in three ways: with a step on every clock, with sparse single-cycle steps on the internal enable, and with pulses on the external event input. Together these separate true step counting from free-running counting and show that the source not selected is ignored. Compare writes are placed just after a period boundary, so that a design updating the compare immediately is caught by a wrong period length or a wrong channel 1 hit point. The channel 1 value is also placed inside and beyond the period, and the mask is toggled. The pins are checked both while toggling and at rest, at both idle levels.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMP0 = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMP1 = 2'd2;

  // Control register layout, bit0 first: run, ext_sel, oe0, lvl0, oe1, lvl1
  typedef struct packed {
    logic lvl1;
    logic oe1;
    logic lvl0;
    logic oe0;
    logic ext_sel;
    logic run;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int unsigned W  = CNT_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  output ctrl_t         ctrl_o,
  output logic [W-1:0]  cmp0_o,
  output logic [W-1:0]  cmp1_o
);
  logic [W-1:0] data_lo;
  assign data_lo = wr_data_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_o <= '0;
      cmp0_o <= '1;
      cmp1_o <= '1;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        AW'(ADDR_CTRL): ctrl_o <= ctrl_t'(data_lo[CTRL_W-1:0]);
        AW'(ADDR_CMP0): cmp0_o <= data_lo;
        AW'(ADDR_CMP1): cmp1_o <= data_lo;
        default: ;
      endcase
    end
  end

  logic unused_hi;
  assign unused_hi = ^data_lo[W-1:CTRL_W];
endmodule

// File: rtl/ivt_tick_sel.sv
module ivt_tick_sel #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_sel_i,
  input  logic int_tick_i,
  input  logic evt_i,
  output logic tick_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   edge_q;
  logic                   ext_tick;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= evt_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], evt_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) edge_q <= 1'b0;
    else        edge_q <= sync_q[LAST];
  end

  assign ext_tick = sync_q[LAST] & ~edge_q;
  assign tick_o   = ext_sel_i ? ext_tick : int_tick_i;

  AST_EXT_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel_i && tick_o) |=> (!ext_sel_i || !tick_o)); // R9
endmodule

// File: rtl/ivt_core.sv
module ivt_core #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         mask_i,
  input  logic [W-1:0] cmp0_i,
  input  logic [W-1:0] cmp1_i,
  output logic [W-1:0] cnt_o,
  output logic         hit0_o,
  output logic         irq0_o,
  output logic         irq1_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] buf0_q;
  logic [W-1:0] buf1_q;
  logic         run_q;
  logic         active;
  logic         start;

  assign active = run_i & run_q;
  assign start  = run_i & ~run_q;
  assign hit0_o = active & tick_i & (cnt_q == buf0_q);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      buf0_q <= '1;
      buf1_q <= '1;
      run_q  <= 1'b0;
      irq0_o <= 1'b0;
      irq1_o <= 1'b0;
    end else begin
      run_q  <= run_i;
      irq0_o <= 1'b0;
      irq1_o <= 1'b0;
      if (!run_i) begin
        cnt_q <= '0;
      end else if (start) begin
        cnt_q  <= '0;
        buf0_q <= cmp0_i;
        buf1_q <= cmp1_i;
      end else if (tick_i) begin
        if (cnt_q == buf1_q) irq1_o <= ~mask_i;
        if (hit0_o) begin
          cnt_q  <= '0;
          buf0_q <= cmp0_i;
          buf1_q <= cmp1_i;
          irq0_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_CNT_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= buf0_q)); // R1
  AST_PERIOD_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq0_o |-> (cnt_q == '0)); // R1
  AST_STOPPED_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (cnt_q == '0)); // R8
  AST_CC1_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mask_i) |-> !irq1_o); // R5
  AST_BUF_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(buf0_q) || !$stable(buf1_q)) |-> (cnt_q == '0)); // R4
  AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_i) && $past(run_q) && !$past(tick_i)) |-> $stable(cnt_q)); // R10
endmodule

// File: rtl/ivt_pin.sv
module ivt_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_i,
  input  logic lvl_i,
  input  logic match_i,
  output logic pin_o
);
  logic tog_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       tog_q <= 1'b0;
    else if (!oe_i)   tog_q <= lvl_i;
    else if (match_i) tog_q <= ~tog_q;
  end

  assign pin_o = oe_i ? tog_q : lvl_i;

  AST_PIN_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_i && $past(oe_i) && $past(match_i)) |-> (pin_o != $past(pin_o))); // R6
endmodule

// File: rtl/ivt_dual_cmp_top.sv
module ivt_dual_cmp_top
  import ivt_pkg::*;
#(
  parameter int unsigned W           = CNT_W,
  parameter int unsigned AW          = ADDR_W,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned N_PINS      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          cnt_tick_i,
  input  logic          evt_i,
  input  logic          cc1_mask_i,
  output logic [W-1:0]  count_o,
  output logic          irq_cc0_o,
  output logic          irq_cc1_o,
  output logic          tout0_o,
  output logic          tout1_o
);
  ctrl_t              ctrl;
  logic [W-1:0]       cmp0;
  logic [W-1:0]       cmp1;
  logic               tick;
  logic               hit0;
  logic [N_PINS-1:0]  pin_oe;
  logic [N_PINS-1:0]  pin_lvl;
  logic [N_PINS-1:0]  pin_out;

  ivt_regs #(.W(W), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl),
    .cmp0_o    (cmp0),
    .cmp1_o    (cmp1)
  );

  ivt_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_sel_i  (ctrl.ext_sel),
    .int_tick_i (cnt_tick_i),
    .evt_i      (evt_i),
    .tick_o     (tick)
  );

  ivt_core #(.W(W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (ctrl.run),
    .tick_i (tick),
    .mask_i (cc1_mask_i),
    .cmp0_i (cmp0),
    .cmp1_i (cmp1),
    .cnt_o  (count_o),
    .hit0_o (hit0),
    .irq0_o (irq_cc0_o),
    .irq1_o (irq_cc1_o)
  );

  assign pin_oe  = {ctrl.oe1, ctrl.oe0};
  assign pin_lvl = {ctrl.lvl1, ctrl.lvl0};

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    ivt_pin u_pin (
      .clk     (clk),
      .rst_n   (rst_n),
      .oe_i    (pin_oe[g]),
      .lvl_i   (pin_lvl[g]),
      .match_i (hit0),
      .pin_o   (pin_out[g])
    );
  end

  assign tout0_o = pin_out[0];
  assign tout1_o = pin_out[1];
endmodule

// File: tb/test_ivt_dual_cmp_top.sv
module test_ivt_dual_cmp_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        cnt_tick_i = 1'b1;
  logic        evt_i = 1'b0;
  logic        cc1_mask_i = 1'b0;
  logic [15:0] count_o;
  logic        irq_cc0_o, irq_cc1_o, tout0_o, tout1_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ivt_dual_cmp_top i_ivt_dual_cmp_top (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .cnt_tick_i(cnt_tick_i), .evt_i(evt_i),
    .cc1_mask_i(cc1_mask_i), .count_o(count_o), .irq_cc0_o(irq_cc0_o),
    .irq_cc1_o(irq_cc1_o), .tout0_o(tout0_o), .tout1_o(tout1_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_irq0(output int stamp);
    stamp = -1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (irq_cc0_o) begin stamp = cyc; break; end
    end
  endtask

  task automatic wait_irq1(output int stamp, output int cnt);
    stamp = -1; cnt = -1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq_cc1_o) begin stamp = cyc; cnt = int'(count_o); break; end
    end
  endtask

  task automatic t_reset;
    chk(count_o == 0, "R2 reset count", int'(count_o), 0);
    chk(!irq_cc0_o && !irq_cc1_o, "R1 reset irqs", int'({irq_cc0_o, irq_cc1_o}), 0);
    chk(!tout0_o && !tout1_o, "R7 reset pins", int'({tout0_o, tout1_o}), 0);
  endtask

  task automatic t_interval;  // R1 R2 R11
    int s0, s1;
    cnt_tick_i = 1'b1;
    wr(2'd1, 16'd4);
    wr(2'd0, 16'h0001);
    wait_irq0(s0);
    chk(s0 >= 0, "R11 start produces period irq", s0, 0);
    chk(count_o == 0, "R1 count zero at period irq", int'(count_o), 0);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk(count_o == 16'(k), "R2 live count", int'(count_o), k);
      chk(!irq_cc0_o, "R1 single-cycle irq", int'(irq_cc0_o), 0);
    end
    wait_irq0(s1);
    chk(s1 - s0 == 5, "R1 period D0+1", s1 - s0, 5);
  endtask

  task automatic t_cc1;  // R3
    int s, c, s2, c2, s0;
    wr(2'd2, 16'd2);
    wait_irq0(s0);
    wait_irq1(s, c);
    chk(c == 3, "R3 cc1 hit point", c, 3);
    wait_irq1(s2, c2);
    chk(s2 - s == 5, "R3 cc1 repeats per period", s2 - s, 5);
    wait_irq0(s0);
    wr(2'd2, 16'd3);
    wait_irq1(s, c);
    chk(c == 3, "R3 old buffer used mid period", c, 3);
    wait_irq1(s, c);
    chk(c == 4, "R3 new buffer after boundary", c, 4);
    wr(2'd2, 16'd9);
    wait_irq0(s0);
    wait_irq0(s0);
    wait_irq1(s, c);
    chk(s == -1, "R3 cc1 beyond period silent", s, -1);
  endtask

  task automatic t_mask;  // R5
    int s, c, s0;
    wr(2'd2, 16'd1);
    wait_irq0(s0);
    cc1_mask_i = 1'b1;
    wait_irq1(s, c);
    chk(s == -1, "R5 masked cc1", s, -1);
    cc1_mask_i = 1'b0;
    wait_irq1(s, c);
    chk(c == 2, "R5 unmasked cc1 returns", c, 2);
  endtask

  task automatic t_cmp0_buffer;  // R4
    int s0, s1, s2, s3;
    wait_irq0(s0);
    wr(2'd1, 16'd7);
    wait_irq0(s1);
    chk(s1 - s0 == 5, "R4 current period unchanged", s1 - s0, 5);
    wait_irq0(s2);
    chk(s2 - s1 == 8, "R4 new period applied", s2 - s1, 8);
    wr(2'd1, 16'd4);
    wait_irq0(s3);
    wait_irq0(s2);
    chk(s2 - s3 == 5, "R4 period restored", s2 - s3, 5);
  endtask

  task automatic t_pins;  // R6 R7
    int s;
    logic p;
    wr(2'd0, 16'b100101);
    wait_irq0(s);
    p = tout0_o;
    chk(tout1_o == 1'b1, "R7 disabled pin high level", int'(tout1_o), 1);
    wait_irq0(s);
    chk(tout0_o != p, "R6 pin toggles per match", int'(tout0_o), int'(!p));
    p = tout0_o;
    repeat (2) @(negedge clk);
    chk(tout0_o == p, "R6 pin steady between matches", int'(tout0_o), int'(p));
    wr(2'd0, 16'b101001);
    chk(tout0_o == 1'b1, "R7 pin0 disabled to high", int'(tout0_o), 1);
    wr(2'd0, 16'b001001);
    chk(tout1_o == 1'b0, "R7 pin1 level low", int'(tout1_o), 0);
  endtask

  task automatic t_stop;  // R8
    int s;
    wr(2'd0, 16'b001000);
    @(negedge clk);
    chk(count_o == 0, "R8 stop clears count", int'(count_o), 0);
    wait_irq0(s);
    chk(s == -1, "R8 no period irq stopped", s, -1);
    chk(count_o == 0, "R8 count stays zero", int'(count_o), 0);
    chk(tout0_o == 1'b1, "R8 idle level after stop", int'(tout0_o), 1);
  endtask

  task automatic t_ext;  // R9
    wr(2'd1, 16'd100);
    cnt_tick_i = 1'b1;
    wr(2'd0, 16'b000011);
    repeat (10) @(negedge clk);
    chk(count_o == 0, "R9 internal tick ignored", int'(count_o), 0);
    for (int k = 0; k < 3; k++) begin
      evt_i = 1'b1; repeat (2) @(negedge clk);
      evt_i = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(count_o == 3, "R9 event edges counted", int'(count_o), 3);
    wr(2'd0, 16'b000000);
  endtask

  task automatic t_gate;  // R10 R9
    cnt_tick_i = 1'b0;
    wr(2'd0, 16'b000001);
    evt_i = 1'b1; repeat (5) @(negedge clk); evt_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(count_o == 0, "R10/R9 no steps no count", int'(count_o), 0);
    for (int k = 0; k < 6; k++) begin
      cnt_tick_i = 1'b1; @(negedge clk);
      cnt_tick_i = 1'b0; repeat (2) @(negedge clk);
    end
    chk(count_o == 6, "R10 counts sparse steps", int'(count_o), 6);
    repeat (5) @(negedge clk);
    chk(count_o == 6, "R10 holds without step", int'(count_o), 6);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_interval();
    t_cc1();
    t_mask();
    t_cmp0_buffer();
    t_pins();
    t_stop();
    t_ext();
    t_gate();
    finish_run();
  end
endmodule